// File: doc/BRIEF.md
# Interrupt Pin Request Servicing with EOI Storm Throttle

This block sits behind the input pins of an interrupt routing controller. Each pin has a request bit that is updated one pin per cycle from a request port. Each pin also has a routing entry, presented on input ports: mask, level or edge trigger type, vector, destination, destination addressing mode and delivery mode. From these the block decides when a pin turns into a delivery message. A message is offered for one cycle, and the fabric answers in the same cycle whether any destination took it. For level-type pins the block keeps a remote-acknowledge bit. That bit is set by an accepted delivery and cleared by an end-of-interrupt broadcast carrying the pin's vector.

A level line that stays asserted is delivered again after every end-of-interrupt. A per-pin counter tracks how many such back-to-back re-deliveries happened. When the count reaches a limit, the pin is parked and a shared hold timer is started. When the timer expires, every level pin with a pending request and a clear acknowledge bit is serviced again. A stuck line therefore slows down instead of locking up the destination.

Top module: `irq_pin_service`

## Requirements
- R1: A request update writes the pin's request bit. An update that asserts a pin whose request bit is already 1 pulses `req_coalesced` in that cycle and produces no message.
- R2: An edge-type pin is offered for delivery only when its request bit goes from 0 to 1. A pin whose entry is edge-type keeps its remote-acknowledge bit at 0.
- R3: No message is produced for a masked pin, nor for a level-type pin whose remote-acknowledge bit is 1.
- R4: A level-type delivery with `dlv_accept` high sets that pin's remote-acknowledge bit. With `dlv_accept` low the bit stays 0.
- R5: A message carries the entry's vector, destination, addressing mode and trigger type (1 = level). `msg_mode` is 11 bits wide, with the 3-bit delivery mode in bits 10:8 and zeros below.
- R6: An end-of-interrupt acts on every pin whose vector matches. It clears remote-acknowledge bits only when `eoi_level` is 1, `eoi_directed` is 0 and the entry is level-type.
- R7: After such a clear, an unmasked pin with its request still set has its successive count incremented and is delivered again. Otherwise its count returns to 0.
- R8: When the successive count reaches STORM_LIMIT, the count returns to 0 and the pin is parked. It is not delivered until the hold timer expires, HOLD_CYCLES cycles after the trigger.
- R9: On expiry, parking is released, and every level-type pin with its request set and remote-acknowledge clear is serviced.
- R10: A storm trigger on another pin while the hold timer runs does not restart the timer.
- R11: At most one message is produced per cycle. Pins that become ready together are delivered in ascending pin order.
- R12: Reset clears all request bits, remote-acknowledge bits, successive counts, parking and the hold timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request update strobe |
| req_pin | input | PIN_W | Pin index of the update |
| req_level | input | 1 | New request value |
| ent_mask | input | NPINS | Per-pin mask |
| ent_level | input | NPINS | Per-pin trigger type, 1 = level |
| ent_vector | input | NPINS*VEC_W | Per-pin vector |
| ent_dest | input | NPINS*DEST_W | Per-pin destination |
| ent_dest_logical | input | NPINS | Per-pin addressing mode |
| ent_dlv_mode | input | NPINS*3 | Per-pin delivery mode |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | End-of-interrupt vector |
| eoi_level | input | 1 | End-of-interrupt is level type |
| eoi_directed | input | 1 | Directed end-of-interrupt mode active |
| dlv_accept | input | 1 | A destination accepted the message this cycle |
| msg_valid | output | 1 | Message offered this cycle |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dest_logical | output | 1 | Message addressing mode |
| msg_level | output | 1 | Message trigger type |
| msg_mode | output | 11 | Delivery mode placed in bits 10:8 |
| remote_irr | output | NPINS | Remote-acknowledge bits |
| req_coalesced | output | 1 | Update did not change a set request |

## Verification
Two functions can fall in the same cycle. The hold timer can release several parked pins at once, and an end-of-interrupt with a shared vector can re-arm two pins together. Both cases are provoked by giving two level pins the same vector and by timing a second storm trigger inside a running hold window. They are judged by the order of messages in the scoreboard queue and by the cycle in which the released messages appear. Messages that arrive late, as a restarted timer would cause, leave entries in the queue and are reported.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  localparam int MODE_W      = 3;
  localparam int MODE_SHIFT  = 8;
  localparam int MSG_MODE_W  = MODE_SHIFT + MODE_W;

  function automatic logic [MSG_MODE_W-1:0] place_mode(input logic [MODE_W-1:0] m);
    place_mode = {m, {MODE_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb grant = req & (~req + N'(1));
endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer #(
  parameter int HOLD_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic expire
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = active_q && (cnt_q == '0);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (expire) begin
      active_d = trigger;
      cnt_d    = CW'(HOLD_CYCLES - 1);
    end else if (active_q) begin
      cnt_d = cnt_q - CW'(1);
    end else if (trigger) begin
      active_d = 1'b1;
      cnt_d    = CW'(HOLD_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  // R10: a running window keeps counting down when another storm arrives
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && trigger && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/irq_pin_slot.sv
module irq_pin_slot #(
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             upd_level,
  input  logic             ent_mask,
  input  logic             ent_level,
  input  logic [VEC_W-1:0] ent_vector,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             eoi_clears,
  input  logic             grant,
  input  logic             accept,
  input  logic             inject,
  output logic             want,
  output logic             eligible,
  output logic             rirr,
  output logic             coalesced,
  output logic             storm
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);

  logic             irr_q, irr_d;
  logic             rirr_q, rirr_d;
  logic             want_q, want_d;
  logic             park_q, park_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise, eoi_hit, redo;

  assign rise      = upd && upd_level && !irr_q;
  assign coalesced = upd && upd_level && irr_q;
  assign eoi_hit   = eoi_valid && eoi_clears && ent_level && (eoi_vector == ent_vector);
  assign redo      = eoi_hit && !ent_mask && irr_q;
  assign storm     = redo && (cnt_q == CNT_W'(STORM_LIMIT - 1));
  assign eligible  = !ent_mask && !(ent_level && (rirr_q || park_q));
  assign want      = want_q;
  assign rirr      = rirr_q;

  always_comb begin
    irr_d = upd ? upd_level : irr_q;

    cnt_d = cnt_q;
    if (eoi_hit) begin
      if (!redo || storm) cnt_d = '0;
      else                cnt_d = cnt_q + CNT_W'(1);
    end

    park_d = storm ? 1'b1 : (inject ? 1'b0 : park_q);

    rirr_d = rirr_q;
    if (eoi_hit) rirr_d = 1'b0;
    if (grant && eligible && ent_level && accept) rirr_d = 1'b1;
    if (!ent_level) rirr_d = 1'b0;

    want_d = grant ? 1'b0 : want_q;
    if (rise || (redo && !storm) || (inject && ent_level && irr_q && !rirr_q))
      want_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      want_q <= 1'b0;
      park_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      irr_q  <= irr_d;
      rirr_q <= rirr_d;
      want_q <= want_d;
      park_q <= park_d;
      cnt_q  <= cnt_d;
    end
  end

  // R2: an edge-type entry leaves the acknowledge bit clear
  assert_edge_no_rirr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_level |=> !rirr_q);
  // R4: the acknowledge bit only rises after an accepted level delivery
  assert_rirr_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr_q) |-> $past(grant && accept && ent_level));
  // R8: the successive count never reaches the limit
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(STORM_LIMIT));
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
  import irq_svc_pkg::*;
#(
  parameter int NPINS       = 4,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int HOLD_CYCLES = 500000,
  localparam int PIN_W      = $clog2(NPINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [PIN_W-1:0]        req_pin,
  input  logic                    req_level,
  input  logic [NPINS-1:0]        ent_mask,
  input  logic [NPINS-1:0]        ent_level,
  input  logic [NPINS*VEC_W-1:0]  ent_vector,
  input  logic [NPINS*DEST_W-1:0] ent_dest,
  input  logic [NPINS-1:0]        ent_dest_logical,
  input  logic [NPINS*MODE_W-1:0] ent_dlv_mode,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  input  logic                    eoi_level,
  input  logic                    eoi_directed,
  input  logic                    dlv_accept,
  output logic                    msg_valid,
  output logic [VEC_W-1:0]        msg_vector,
  output logic [DEST_W-1:0]       msg_dest,
  output logic                    msg_dest_logical,
  output logic                    msg_level,
  output logic [MSG_MODE_W-1:0]   msg_mode,
  output logic [NPINS-1:0]        remote_irr,
  output logic                    req_coalesced
);
  logic [NPINS-1:0] want, grant, eligible, coal, storm;
  logic             inject;
  logic [MODE_W-1:0] sel_mode;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    irq_pin_slot #(.VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd        (req_valid && (req_pin == PIN_W'(i))),
      .upd_level  (req_level),
      .ent_mask   (ent_mask[i]),
      .ent_level  (ent_level[i]),
      .ent_vector (ent_vector[i*VEC_W +: VEC_W]),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .eoi_clears (eoi_level && !eoi_directed),
      .grant      (grant[i]),
      .accept     (dlv_accept),
      .inject     (inject),
      .want       (want[i]),
      .eligible   (eligible[i]),
      .rirr       (remote_irr[i]),
      .coalesced  (coal[i]),
      .storm      (storm[i])
    );
  end

  irq_low_pick #(.N(NPINS)) u_pick (.req(want), .grant(grant));

  irq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .trigger(|storm), .expire(inject)
  );

  assign req_coalesced = |coal;
  assign msg_valid     = |(grant & eligible);

  always_comb begin
    msg_vector       = '0;
    msg_dest         = '0;
    msg_dest_logical = 1'b0;
    msg_level        = 1'b0;
    sel_mode         = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (grant[i]) begin
        msg_vector       = msg_vector | ent_vector[i*VEC_W +: VEC_W];
        msg_dest         = msg_dest | ent_dest[i*DEST_W +: DEST_W];
        msg_dest_logical = msg_dest_logical | ent_dest_logical[i];
        msg_level        = msg_level | ent_level[i];
        sel_mode         = sel_mode | ent_dlv_mode[i*MODE_W +: MODE_W];
      end
    end
    msg_mode = msg_valid ? place_mode(sel_mode) : '0;
  end

  // R11: one pin wins per cycle
  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R3: a produced message never belongs to a masked pin
  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((grant & ent_mask) == '0));
endmodule

// File: tb/test_irq_pin_service.sv
module test_irq_pin_service;
  localparam int NP = 4, VW = 8, DW = 8, LIM = 3, HOLD = 40;
  localparam int MW = VW + DW + 1 + 1 + 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_level, eoi_valid, eoi_level, eoi_directed, dlv_accept;
  logic [1:0] req_pin;
  logic [NP-1:0] tm, tl, tlog;
  logic [VW-1:0] tv [NP];
  logic [DW-1:0] td [NP];
  logic [2:0]    tmode [NP];
  logic [NP*VW-1:0] pv;
  logic [NP*DW-1:0] pd;
  logic [NP*3-1:0]  pm;
  logic [VW-1:0] eoi_vector;
  logic msg_valid, msg_dest_logical, msg_level, req_coalesced;
  logic [VW-1:0] msg_vector;
  logic [DW-1:0] msg_dest;
  logic [10:0] msg_mode;
  logic [NP-1:0] remote_irr;

  always_comb for (int i = 0; i < NP; i++) begin
    pv[i*VW +: VW] = tv[i];
    pd[i*DW +: DW] = td[i];
    pm[i*3 +: 3]   = tmode[i];
  end

  irq_pin_service #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW), .STORM_LIMIT(LIM),
                    .HOLD_CYCLES(HOLD)) i_irq_pin_service (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin),
    .req_level(req_level), .ent_mask(tm), .ent_level(tl), .ent_vector(pv),
    .ent_dest(pd), .ent_dest_logical(tlog), .ent_dlv_mode(pm),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
    .eoi_directed(eoi_directed), .dlv_accept(dlv_accept), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical),
    .msg_level(msg_level), .msg_mode(msg_mode), .remote_irr(remote_irr),
    .req_coalesced(req_coalesced));

  int checks = 0, fails = 0, seen = 0;
  logic [MW-1:0] expq [$];

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] model_msg(input int p);
    return {tv[p], td[p], tlog[p], tl[p], tmode[p], 8'h00};
  endfunction

  task automatic expect_msg(input int p);
    expq.push_back(model_msg(p));
  endtask

  // monitor: pops the scoreboard (R5 fields, R11 order)
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && msg_valid) begin
      logic [MW-1:0] got;
      got = {msg_vector, msg_dest, msg_dest_logical, msg_level, msg_mode};
      seen++;
      if (expq.size() == 0) chk(1'b0, "R3 unexpected message", 32'(got), 0);
      else begin
        logic [MW-1:0] e;
        e = expq.pop_front();
        chk(got == e, "R5 R11 message fields/order", 32'(got), 32'(e));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input int p, input logic lv, input int coal_exp);
    req_valid = 1'b1; req_pin = 2'(p); req_level = lv;
    #5;
    if (coal_exp >= 0)
      chk(req_coalesced == 1'(coal_exp), "R1 coalesced flag", 32'(req_coalesced), 32'(coal_exp));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic eoi(input logic [VW-1:0] v, input logic lv, input logic dir);
    eoi_valid = 1'b1; eoi_vector = v; eoi_level = lv; eoi_directed = dir;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n0;
    rst_n = 1'b0; req_valid = 0; req_pin = 0; req_level = 0;
    eoi_valid = 0; eoi_vector = 0; eoi_level = 0; eoi_directed = 0; dlv_accept = 1;
    tm = '0; tl = 4'b1110; tlog = 4'b0010;
    tv[0] = 8'h30; td[0] = 8'h01; tmode[0] = 3'd0;
    tv[1] = 8'h41; td[1] = 8'h02; tmode[1] = 3'd1;
    tv[2] = 8'h52; td[2] = 8'h03; tmode[2] = 3'd2;
    tv[3] = 8'h41; td[3] = 8'h04; tmode[3] = 3'd7;
    tick(3);
    chk(msg_valid == 0, "R12 reset msg_valid", 32'(msg_valid), 0);
    chk(remote_irr == 0, "R12 reset remote_irr", 32'(remote_irr), 0);
    rst_n = 1'b1;
    tick(1);

    // edge pin: rising request delivers, repeats coalesce (R1, R2)
    expect_msg(0); req(0, 1, 0); tick(2);
    chk(remote_irr[0] == 0, "R2 edge pin ack stays clear", 32'(remote_irr), 0);
    req(0, 1, 1); tick(2);
    req(0, 0, 0); expect_msg(0); req(0, 1, 0); tick(2);
    chk(expq.size() == 0, "R2 edge deliveries", expq.size(), 0);

    // level pin accepted (R4), EOI filtering (R6)
    expect_msg(1); req(1, 1, 0); tick(2);
    chk(remote_irr[1] == 1, "R4 accepted level sets ack", 32'(remote_irr), 32'h2);
    req(1, 1, 1);
    eoi(8'h41, 0, 0); tick(2);
    chk(remote_irr[1] == 1, "R6 edge-type EOI ignored", 32'(remote_irr), 32'h2);
    eoi(8'h41, 1, 1); tick(2);
    chk(remote_irr[1] == 1, "R6 directed EOI ignored", 32'(remote_irr), 32'h2);
    expect_msg(3); req(3, 1, 0); tick(2);

    // shared vector: both pins re-armed, ascending order (R6, R7, R11)
    expect_msg(1); expect_msg(3); eoi(8'h41, 1, 0); tick(3);
    chk(remote_irr[1] && remote_irr[3], "R7 redelivery resets ack", 32'(remote_irr), 32'ha);
    chk(expq.size() == 0, "R6 both vector matches served", expq.size(), 0);
    expect_msg(1); expect_msg(3); eoi(8'h41, 1, 0); tick(3);
    expect_msg(2); req(2, 1, 0); tick(2);
    expect_msg(2); eoi(8'h52, 1, 0); tick(3);
    expect_msg(2); eoi(8'h52, 1, 0); tick(3);

    // storm on pins 1 and 3, second storm on pin 2 inside window (R8, R9, R10)
    eoi(8'h41, 1, 0);
    chk(remote_irr[1] == 0 && remote_irr[3] == 0, "R8 parked pins ack clear", 32'(remote_irr), 32'h4);
    tick(4);
    eoi(8'h52, 1, 0);
    expect_msg(1); expect_msg(2); expect_msg(3);
    tick(HOLD - 8);
    chk(expq.size() == 3, "R8 parked pins held back", expq.size(), 3);
    tick(8);
    chk(expq.size() == 0, "R9 R10 release at first expiry", expq.size(), 0);

    // gating (R3)
    n0 = seen;
    req(0, 0, 0); tm[0] = 1'b1; req(0, 1, 0); tick(4);
    chk(seen == n0, "R3 masked edge pin silent", seen - n0, 0);
    tm[0] = 1'b0;
    req(1, 0, 0); req(1, 1, 0); tick(4);
    chk(seen == n0, "R3 level pin blocked by ack", seen - n0, 0);

    // refused delivery leaves ack clear (R4)
    req(1, 0, 0); req(2, 0, 0); req(3, 0, 0);
    eoi(8'h41, 1, 0); eoi(8'h52, 1, 0); tick(1);
    chk(remote_irr == 0, "R6 all acks cleared", 32'(remote_irr), 0);
    dlv_accept = 1'b0;
    expect_msg(1); req(1, 1, 0); tick(2);
    chk(remote_irr[1] == 0, "R4 refused level keeps ack clear", 32'(remote_irr), 0);
    dlv_accept = 1'b1;
    req(1, 0, 0);

    // reset clears request state (R12)
    expect_msg(3); req(3, 1, 0); tick(2);
    chk(remote_irr[3] == 1, "R4 ack before reset", 32'(remote_irr), 32'h8);
    rst_n = 1'b0; tick(2);
    chk(remote_irr == 0, "R12 ack cleared", 32'(remote_irr), 0);
    chk(msg_valid == 0, "R12 no message in reset", 32'(msg_valid), 0);
    rst_n = 1'b1; tick(1);
    expect_msg(3); req(3, 1, 0); tick(2);
    chk(expq.size() == 0, "R12 request bit cleared", expq.size(), 0);

    // count returns to zero when the request is gone (R7)
    expect_msg(3); eoi(8'h41, 1, 0); tick(2);
    expect_msg(3); eoi(8'h41, 1, 0); tick(2);
    req(3, 0, 0); eoi(8'h41, 1, 0); tick(2);
    expect_msg(3); req(3, 1, 0); tick(2);
    expect_msg(3); eoi(8'h41, 1, 0); tick(2);
    expect_msg(3); eoi(8'h41, 1, 0); tick(3);
    chk(expq.size() == 0, "R7 count reset by idle EOI", expq.size(), 0);

    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule